// File: doc/BRIEF.md
# Self-Clocked Converter Readout Sequencer

This block runs the digital readout side of a converter that supplies its own serial clock. A conversion timer stands in for the analog core. It counts a programmable number of system cycles, pulses a done strobe, and captures a 23-bit result word. The word is held together with an end-of-conversion flag of 0 as a 24-bit frame. The block then sleeps until an active-low select is asserted.

If the serial clock pin is high when select falls, the block counts a fixed start delay. It then drives its own serial clock and shifts the frame out MSB first. If the pin is low when select falls, the block never drives the clock. It shifts on clock edges from an external master instead. Raising select during the start delay leaves the held result untouched. Raising select during a frame abandons the readout and starts a new conversion. The end of a full frame also starts a new conversion.

The clock pin is bidirectional. It is modelled as a drive value with a drive enable, plus the level sensed on the pin. When the block releases the pin, the board pulls it high.

Top module: `adc_readout_seq`

## Requirements
- R1: After reset the block is converting: `eoc` is 1, `conv_done` is 0, and with `cs_n` high both `sck_oe` and `sdo_oe` are 0.
- R2: A conversion lasts CONV_CYC cycles, and `conv_done` is high for exactly one of them, the last. After `conv_done`, `eoc` is 0 and the held frame is {1'b0, `conv_word`}, with frame bit 23 as the end-of-conversion flag and bits 22..0 as the word.
- R3: `sdo_oe` follows `cs_n` low, and `sck_oe` is 0 whenever `cs_n` is high. While selected, `sdo` reads 1 during a conversion and 0 while a result is waiting.
- R4: Internal-clock start. When `cs_n` is first sampled low in sleep with the clock pin high, `sck_out` is driven low. It rises (serial rising edge 1) WAIT_CYC clock edges later.
- R5: If `cs_n` rises before the start delay ends, the block returns to sleep. No new conversion runs and the held frame is read out unchanged later.
- R6: If `cs_n` is already low when a conversion ends, the start delay begins at that point. `sck_out` rises WAIT_CYC+1 clock edges after the edge that ends the conversion.
- R7: The internal clock toggles every HALF_CYC system cycles. `sdo` changes only at falling serial edges, and the bits at successive rising edges are frame bits 23 down to 0.
- R8: Half a serial period after rising edge 24, the block returns to conversion. At that point `eoc` is 1, `sdo` is driven to 1 while selected, and the released clock pin stays high.
- R9: A rise of `cs_n` during a frame aborts it. On the next cycle `eoc` is 1 and both drivers are released. The new conversion's `conv_done` follows CONV_CYC-1 cycles later.
- R10: If the clock pin is low when `cs_n` falls, `sck_oe` stays 0. The frame shifts on external falling edges, MSB first. The falling edge after the 24th external rise starts a conversion.
- R11: An internal-clock frame contains exactly 24 rising serial edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low select |
| sck_in | input | 1 | Level sensed on the serial clock pin |
| conv_word | input | 23 | Result word captured when a conversion ends |
| conv_done | output | 1 | One-cycle conversion-finished strobe |
| eoc | output | 1 | High while converting |
| sck_out | output | 1 | Serial clock drive value |
| sck_oe | output | 1 | Serial clock drive enable |
| sdo | output | 1 | Serial data value |
| sdo_oe | output | 1 | Serial data drive enable |

## Verification
The hardest situation to reach is R6, where select is already low when a conversion finishes. A plain readout never produces it, because it raises select as soon as a frame ends. The bench therefore aborts a frame after five rising edges, which restarts conversion. It then pulls select low again midway through that conversion and times the first serial rising edge from the done strobe. External-clock mode is reached by having the bench itself hold the clock pin low at the instant select falls.

// File: rtl/adc_readout_seq.sv
module adc_readout_seq #(
  parameter int FRAME_BITS = 24,
  parameter int CONV_CYC   = 40,
  parameter int WAIT_CYC   = 8,
  parameter int HALF_CYC   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_n,
  input  logic                  sck_in,
  input  logic [FRAME_BITS-2:0] conv_word,
  output logic                  conv_done,
  output logic                  eoc,
  output logic                  sck_out,
  output logic                  sck_oe,
  output logic                  sdo,
  output logic                  sdo_oe
);
  localparam int MAXC = (CONV_CYC > WAIT_CYC) ? ((CONV_CYC > HALF_CYC) ? CONV_CYC : HALF_CYC)
                                              : ((WAIT_CYC > HALF_CYC) ? WAIT_CYC : HALF_CYC);
  localparam int CW = $clog2(MAXC + 1);
  localparam int BW = $clog2(FRAME_BITS + 1);

  typedef enum logic [2:0] {S_CONV, S_SLEEP, S_WAIT, S_OUT, S_XOUT} st_t;

  st_t                   state;
  logic [CW-1:0]         cnt;
  logic [BW-1:0]         bitcnt;
  logic [FRAME_BITS-1:0] shreg;
  logic                  sck_q, cs_q, sck_in_q, ext_q;

  wire cs_fall = cs_q & ~cs_n;
  wire ext_now = cs_fall ? ~sck_in : ext_q;
  wire tick    = (cnt == CW'(HALF_CYC - 1));
  wire x_rise  = ~sck_in_q & sck_in;
  wire x_fall  = sck_in_q & ~sck_in;
  wire last    = (bitcnt == BW'(FRAME_BITS));

  assign conv_done = (state == S_CONV) && (cnt == CW'(CONV_CYC - 1));
  assign eoc       = (state == S_CONV);
  assign sck_out   = sck_q;
  assign sck_oe    = ~cs_n && (state == S_WAIT || state == S_OUT);
  assign sdo_oe    = ~cs_n;
  assign sdo       = eoc | shreg[FRAME_BITS-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_CONV;
      cnt      <= '0;
      bitcnt   <= '0;
      shreg    <= '1;
      sck_q    <= 1'b1;
      cs_q     <= 1'b1;
      sck_in_q <= 1'b1;
      ext_q    <= 1'b0;
    end else begin
      cs_q     <= cs_n;
      sck_in_q <= sck_in;
      if (cs_fall) ext_q <= ~sck_in;
      case (state)
        S_CONV: begin
          sck_q <= 1'b1;
          if (conv_done) begin
            state <= S_SLEEP;
            cnt   <= '0;
            shreg <= {1'b0, conv_word};
          end else cnt <= cnt + 1'b1;
        end
        S_SLEEP: if (!cs_n) begin
          cnt    <= '0;
          bitcnt <= '0;
          if (ext_now) state <= S_XOUT;
          else begin
            state <= S_WAIT;
            sck_q <= 1'b0;
          end
        end
        S_WAIT: begin
          if (cs_n) begin
            state <= S_SLEEP;
            sck_q <= 1'b1;
          end else if (cnt == CW'(WAIT_CYC - 1)) begin
            state  <= S_OUT;
            sck_q  <= 1'b1;
            bitcnt <= BW'(1);
            cnt    <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_OUT: begin
          if (cs_n) begin
            state <= S_CONV;
            cnt   <= '0;
            sck_q <= 1'b1;
          end else if (tick) begin
            cnt <= '0;
            if (sck_q) begin
              if (last) state <= S_CONV;
              else begin
                sck_q <= 1'b0;
                shreg <= {shreg[FRAME_BITS-2:0], 1'b1};
              end
            end else begin
              sck_q  <= 1'b1;
              bitcnt <= bitcnt + 1'b1;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_XOUT: begin
          if (cs_n) begin
            state <= S_CONV;
            cnt   <= '0;
          end else if (x_rise && !last) bitcnt <= bitcnt + 1'b1;
          else if (x_fall) begin
            if (last) begin
              state <= S_CONV;
              cnt   <= '0;
            end else shreg <= {shreg[FRAME_BITS-2:0], 1'b1};
          end
        end
        default: state <= S_CONV;
      endcase
    end
  end

  assert_done_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> (!eoc && state == S_SLEEP));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && cs_n) |=> (state == S_SLEEP && $stable(shreg)));

  assert_first_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_OUT && $past(state) == S_WAIT) |-> (sck_out && bitcnt == BW'(1)));

  assert_end_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_OUT && !cs_n && tick && sck_q && last) |=> (eoc && sck_out));

  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && (state == S_OUT || state == S_XOUT)) |=> eoc);

  assert_edge_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= BW'(FRAME_BITS));
endmodule

// File: tb/adc_readout_seq_bench.sv
module adc_readout_seq_bench;
  localparam int CONV_CYC = 40;
  localparam int WAIT_CYC = 8;
  localparam int HALF_CYC = 2;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1;
  logic ext_en = 1'b0, ext_val = 1'b0;
  logic [22:0] word_in = '0;
  logic conv_done, eoc, sck_out, sck_oe, sdo, sdo_oe;
  wire  sck_pin = sck_oe ? sck_out : (ext_en ? ext_val : 1'b1);

  int n_chk = 0, n_err = 0, n_done = 0;

  always #5 clk = ~clk;

  adc_readout_seq #(.FRAME_BITS(24), .CONV_CYC(CONV_CYC), .WAIT_CYC(WAIT_CYC), .HALF_CYC(HALF_CYC))
  u_adc_readout_seq (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_in(sck_pin), .conv_word(word_in),
    .conv_done(conv_done), .eoc(eoc), .sck_out(sck_out), .sck_oe(sck_oe),
    .sdo(sdo), .sdo_oe(sdo_oe));

  always @(posedge clk) if (rst_n && conv_done) n_done++;

  // {word fed to the conversion, expected 24-bit frame}
  localparam logic [46:0] VEC [5] = '{
    {23'h7FFFFF, 24'h7FFFFF}, {23'h000000, 24'h000000}, {23'h555555, 24'h555555},
    {23'h2AAAAA, 24'h2AAAAA}, {23'h400001, 24'h400001}};

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_sleep();
    int g = 0;
    while (eoc && g < 2000) begin @(negedge clk); g++; end
  endtask

  task automatic readout(output logic [23:0] got, output int rises, output int per);
    int m = 0, r1 = 0;
    logic ps, pd;
    bit bad = 0;
    got = '0; rises = 0; per = 0;
    ps = sck_out; pd = sdo;
    cs_n = 1'b0;
    do begin
      @(negedge clk); m++;
      if (m == 1) check(sdo_oe && !sdo, "R3", "sdo shows held result", sdo, 0);
      if (m == WAIT_CYC) check(sck_oe && !sck_out, "R4", "sck low before delay ends", sck_out, 0);
      if (m == WAIT_CYC + 1) check(sck_out, "R4", "first rise after delay", sck_out, 1);
      if (!ps && sck_out && sck_oe) begin
        rises++;
        got = {got[22:0], sdo};
        if (rises == 1) r1 = m;
        if (rises == 2) per = m - r1;
      end
      if (sdo != pd && !eoc && !(ps && !sck_out)) bad = 1;
      ps = sck_out; pd = sdo;
    end while (!eoc && m < 4000);
    check(!bad, "R7", "sdo changed only at falling edges", bad, 0);
    check(eoc && sdo && sdo_oe && sck_pin, "R8", "end of frame state",
          {eoc, sdo, sdo_oe, sck_pin}, 4'hF);
    cs_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [23:0] got;
    int rises, per, k;

    // R1 / R2: reset state and first conversion timing
    word_in = VEC[0][46:24];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(eoc && !conv_done && !sck_oe && !sdo_oe, "R1", "reset state",
          {eoc, conv_done, sck_oe, sdo_oe}, 4'h8);
    k = 0;
    while (!conv_done && k < 500) begin @(negedge clk); k++; end
    check(k == CONV_CYC - 1, "R2", "cycles to conv_done", k, CONV_CYC - 1);
    @(negedge clk);
    check(!conv_done && !eoc, "R2", "strobe one cycle, eoc low", {conv_done, eoc}, 0);

    // table walk: one internal-clock frame per word
    for (int i = 0; i < 5; i++) begin
      wait_sleep();
      readout(got, rises, per);
      check(got == VEC[i][23:0], "R7", "frame bits MSB first", got, VEC[i][23:0]);
      check(rises == 24, "R11", "rising edges per frame", rises, 24);
      check(per == 2 * HALF_CYC, "R7", "serial period", per, 2 * HALF_CYC);
      if (i < 4) word_in = VEC[i+1][46:24];
      else word_in = 23'h123456;
    end

    // R5: select pulse shorter than the delay keeps the held word
    wait_sleep();
    word_in = 23'h6EDCBA;
    k = n_done;
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!eoc && n_done == k && !sck_oe, "R5", "stayed in sleep",
          {eoc, sck_oe}, 0);
    readout(got, rises, per);
    check(got == {1'b0, 23'h123456}, "R5", "held word unchanged", got, {1'b0, 23'h123456});

    // R9 abort, then R6 select already low when conversion ends
    wait_sleep();
    begin
      logic ps;
      int r;
      ps = sck_out; r = 0;
      cs_n = 1'b0;
      while (r < 5) begin
        @(negedge clk);
        if (!ps && sck_out) r++;
        ps = sck_out;
      end
    end
    cs_n = 1'b1;
    @(negedge clk);
    check(eoc && !sck_oe && !sdo_oe, "R9", "abort releases and converts",
          {eoc, sck_oe, sdo_oe}, 4);
    word_in = 23'h3C5A96;
    k = 0;
    while (!conv_done && k < 500) begin
      @(negedge clk); k++;
      if (k == 5) cs_n = 1'b0;
      if (k == 6) check(sdo_oe && sdo, "R3", "sdo high while converting", sdo, 1);
    end
    check(k == CONV_CYC - 1, "R9", "conversion after abort", k, CONV_CYC - 1);
    repeat (WAIT_CYC + 1) @(negedge clk);
    check(sck_oe && !sck_out, "R6", "sck low before delay from eoc fall", sck_out, 0);
    @(negedge clk);
    check(sck_out, "R6", "first rise counted from eoc fall", sck_out, 1);
    cs_n = 1'b1;
    @(negedge clk);

    // R10: external clock mode
    wait_sleep();
    begin
      bit drv;
      drv = 0; got = '0;
      ext_en = 1'b1; ext_val = 1'b0;
      @(negedge clk);
      cs_n = 1'b0;
      for (int b = 0; b < 24; b++) begin
        repeat (3) @(negedge clk);
        if (sck_oe) drv = 1;
        got = {got[22:0], sdo};
        ext_val = 1'b1;
        repeat (3) @(negedge clk);
        if (sck_oe) drv = 1;
        ext_val = 1'b0;
      end
      repeat (3) @(negedge clk);
      check(got == {1'b0, 23'h3C5A96}, "R10", "external clock frame", got, {1'b0, 23'h3C5A96});
      check(!drv, "R10", "clock never driven", drv, 0);
      check(eoc && sdo, "R10", "conversion after 24th falling", {eoc, sdo}, 3);
      ext_en = 1'b0;
      cs_n = 1'b1;
    end

    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule